// File: doc/BRIEF.md
# Frame-Modulation Temporal Dither

This block narrows each colour channel of a pixel stream to 8 or 6 bits. It does not simply drop the low bits. For each pixel it decides whether to raise the truncated code by one, so that over a cycle of four frames the average output comes close to the value that was cut off. The two most significant discarded bits form a grey level. Level 0 never rounds up. Levels 1, 2 and 3 round up on one, two or three of every four phase slots. The phase slot depends on the pixel's position in a 2x2 tile, a 2-bit frame counter and a per-channel offset.

The phase comes from two small tables. The spatial table S maps the tile position to a phase, and the temporal table T maps the frame count to a phase. Both tables are either built in or taken from configuration inputs. A stripe-order bit swaps the red and blue offsets to suit panels with BGR sub-pixel order. When dithering is disabled the block performs plain truncation. Output is registered, with one cycle of latency.

Top module: `fm_dither`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock cycle. Channel outputs take the result for a valid pixel one cycle after that pixel, and hold their value while `in_valid` is low.
- R2: During synchronous reset (`rst_n` low) the block clears `out_valid`, all channel outputs and the frame counter to zero.
- R3: With `cfg_en` low, each output equals the truncated input at the selected depth and never rounds up.
- R4: With `cfg_deep`=1, the truncated code is `in[IN_W-1:IN_W-8]` and the grey level is the next two bits. With `cfg_deep`=0, the truncated code is `in[IN_W-1:IN_W-6]`, placed in output bits [5:0] with bits [7:6] at zero, and the grey level is the next two bits.
- R5: A grey level of 0 never rounds up.
- R6: A channel with grey level g rounds up exactly when (s + t + c) mod 4 < g. Here s is the spatial phase, t is the temporal phase and c is the channel offset.
- R7: With `cfg_prog`=0, s is 0, 1, 3 or 2 for tile index {y[0],x[0]} = 0, 1, 2 or 3, and t equals the frame counter.
- R8: With `cfg_prog`=1, s is `cfg_smat[2i+1:2i]` with i = {y[0],x[0]}, and t is `cfg_tmat[2f+1:2f]` with f the frame counter.
- R9: With `cfg_bgr`=0 the channel offsets are R=0, G=1, B=2. With `cfg_bgr`=1 they are R=2, G=1, B=0.
- R10: The frame counter advances by one, modulo 4, on each cycle where `frame_start` is high. The new count applies to pixels in later cycles.
- R11: A round-up on a truncated code that is already at its maximum (255 or 63) leaves the output at that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cfg_en | input | 1 | Temporal dither enable |
| cfg_deep | input | 1 | 1: 8-bit output, 0: 6-bit output |
| cfg_prog | input | 1 | 1: programmable tables, 0: built-in tables |
| cfg_bgr | input | 1 | 1: BGR stripe order, 0: RGB |
| cfg_smat | input | 8 | Spatial phase table, four 2-bit entries |
| cfg_tmat | input | 8 | Temporal phase table, four 2-bit entries |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | XW | Pixel column |
| in_y | input | YW | Pixel row |
| in_r | input | IN_W | Red input |
| in_g | input | IN_W | Green input |
| in_b | input | IN_W | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | OUT_W | Red output |
| out_g | output | OUT_W | Green output |
| out_b | output | OUT_W | Blue output |

## Verification
The bench sweeps every combination of depth, stripe order and table source. For each combination it covers all four frame phases and every 2x2 tile position, and applies a mix of channel values that covers all four grey levels as well as the all-ones saturation code. The frame sweep separates a wrong temporal phase from a wrong spatial one. Giving the three channels different values catches swapped or mis-offset channels. The programmable pass uses tables that differ from the built-in ones, which exposes a wrong table selection. A final pass with dithering disabled separates pure truncation from rounding at both depths.

// File: rtl/tdith_pkg.sv
// Package: shared constants and helpers for the temporal dither.
// Assumes phase tables hold four 2-bit entries packed into 8 bits.
package tdith_pkg;
    typedef logic [1:0] phase_t;

    // Built-in spatial table: index {y0,x0} -> 0,1,3,2
    localparam logic [7:0] S_BUILTIN = 8'b10_11_01_00;
    // Built-in temporal table: identity on the frame count
    localparam logic [7:0] T_BUILTIN = 8'b11_10_01_00;

    // Pick one 2-bit entry from a packed 4-entry table
    function automatic phase_t pick_entry(input logic [7:0] tbl, input logic [1:0] idx);
        phase_t r;
        case (idx)
            2'd0: r = tbl[1:0];
            2'd1: r = tbl[3:2];
            2'd2: r = tbl[5:4];
            default: r = tbl[7:6];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tdith_frame_ctr.sv
// Module: 2-bit frame phase counter.
// Advances on every frame_start pulse and wraps modulo 4.
// Assumes frame_start is synchronous to clk.
module tdith_frame_ctr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    output logic [1:0] frame_cnt
);
    // Count frame starts; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= 2'd0;
        else if (frame_start)
            frame_cnt <= frame_cnt + 2'd1;
    end

    assert_frame_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_cnt == $past(frame_cnt) + 2'd1);
    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_cnt));
endmodule

// File: rtl/tdith_phase.sv
// Module: combinational base phase generator.
// Combines the spatial phase (from the 2x2 tile index) with the temporal
// phase (from the frame count). Each comes from the built-in or the
// programmable table. Assumes only bit 0 of x and y matters.
module tdith_phase
    import tdith_pkg::*;
(
    input  logic       cfg_prog,
    input  logic [7:0] cfg_smat,
    input  logic [7:0] cfg_tmat,
    input  logic       x_lsb,
    input  logic       y_lsb,
    input  logic [1:0] frame_cnt,
    output phase_t     base_phase
);
    logic [7:0] s_tbl;
    logic [7:0] t_tbl;
    phase_t     s_ph;
    phase_t     t_ph;

    // Select table source
    always_comb begin
        s_tbl = cfg_prog ? cfg_smat : S_BUILTIN;
        t_tbl = cfg_prog ? cfg_tmat : T_BUILTIN;
    end

    // Look up both phases and sum them modulo 4
    always_comb begin
        s_ph       = pick_entry(s_tbl, {y_lsb, x_lsb});
        t_ph       = pick_entry(t_tbl, frame_cnt);
        base_phase = s_ph + t_ph;
    end
endmodule

// File: rtl/tdith_chan.sv
// Module: one colour channel of the temporal dither.
// Truncates to 8 or 6 bits, derives the 2-bit grey level, decides
// round-up against the channel phase and saturates at the maximum code.
// Assumes IN_W >= OUT_W + 2 and OUT_W > LO_W. CH is 0/1/2 for R/G/B.
module tdith_chan #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8,
    parameter int LO_W  = 6,
    parameter int CH    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_val,
    input  logic             cfg_en,
    input  logic             cfg_deep,
    input  logic             cfg_bgr,
    input  logic [1:0]       base_phase,
    output logic [OUT_W-1:0] res
);
    localparam int PAD_W = OUT_W - LO_W;
    localparam logic [OUT_W-1:0] MAX_LO = OUT_W'((1 << LO_W) - 1);
    localparam logic [1:0] OFF_RGB = 2'(CH);
    localparam logic [1:0] OFF_BGR = 2'(2 - CH);

    logic [OUT_W-1:0] trunc;
    logic [1:0]       grey;
    logic [OUT_W-1:0] max_code;
    logic [1:0]       off;
    logic [1:0]       ch_phase;
    logic             up;
    logic [OUT_W-1:0] next_val;

    // Split input into kept code and grey level for the chosen depth
    always_comb begin
        if (cfg_deep) begin
            trunc    = in_val[IN_W-1 -: OUT_W];
            grey     = in_val[IN_W-OUT_W-1 -: 2];
            max_code = '1;
        end else begin
            trunc    = {{PAD_W{1'b0}}, in_val[IN_W-1 -: LO_W]};
            grey     = in_val[IN_W-LO_W-1 -: 2];
            max_code = MAX_LO;
        end
    end

    // Per-channel phase offset, swapped for BGR stripes
    always_comb begin
        off      = cfg_bgr ? OFF_BGR : OFF_RGB;
        ch_phase = base_phase + off;
    end

    // Round-up decision and saturating increment
    always_comb begin
        up = cfg_en && (ch_phase < grey);
        if (up && (trunc != max_code))
            next_val = trunc + OUT_W'(1);
        else
            next_val = trunc;
    end

    // Output register, updated only for valid pixels
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (in_valid)
            res <= next_val;
    end

    assert_off_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_en |=> res == $past(trunc));
    assert_lo_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_deep |=> res[OUT_W-1:LO_W] == '0);
    assert_grey0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && grey == 2'd0 |=> res == $past(trunc));
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res == $past(trunc)) || (res == $past(trunc) + OUT_W'(1)));
    assert_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && trunc == max_code |=> res == $past(max_code));
endmodule

// File: rtl/fm_dither.sv
// Module: frame-modulation temporal dither, top level.
// Three channel slices share one frame counter and one base phase
// generator. Output is registered with one cycle of latency.
// Assumes a single clock and a synchronous active-low reset.
module fm_dither #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8,
    parameter int LO_W  = 6,
    parameter int XW    = 12,
    parameter int YW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             cfg_en,
    input  logic             cfg_deep,
    input  logic             cfg_prog,
    input  logic             cfg_bgr,
    input  logic [7:0]       cfg_smat,
    input  logic [7:0]       cfg_tmat,
    input  logic             in_valid,
    input  logic [XW-1:0]    in_x,
    input  logic [YW-1:0]    in_y,
    input  logic [IN_W-1:0]  in_r,
    input  logic [IN_W-1:0]  in_g,
    input  logic [IN_W-1:0]  in_b,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);
    localparam int NCH = 3;

    logic [1:0]       frame_cnt;
    logic [1:0]       base_phase;
    logic [IN_W-1:0]  ch_in  [NCH];
    logic [OUT_W-1:0] ch_out [NCH];

    tdith_frame_ctr u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_cnt  (frame_cnt)
    );

    tdith_phase u_phase (
        .cfg_prog  (cfg_prog),
        .cfg_smat  (cfg_smat),
        .cfg_tmat  (cfg_tmat),
        .x_lsb     (in_x[0]),
        .y_lsb     (in_y[0]),
        .frame_cnt (frame_cnt),
        .base_phase(base_phase)
    );

    // Gather channel inputs in R, G, B order
    always_comb begin
        ch_in[0] = in_r;
        ch_in[1] = in_g;
        ch_in[2] = in_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdith_chan #(
            .IN_W (IN_W),
            .OUT_W(OUT_W),
            .LO_W (LO_W),
            .CH   (c)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_val    (ch_in[c]),
            .cfg_en    (cfg_en),
            .cfg_deep  (cfg_deep),
            .cfg_bgr   (cfg_bgr),
            .base_phase(base_phase),
            .res       (ch_out[c])
        );
    end

    // Scatter channel results onto output ports
    always_comb begin
        out_r = ch_out[0];
        out_g = ch_out[1];
        out_b = ch_out[2];
    end

    // Output valid register
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_r) && $stable(out_g) && $stable(out_b));
endmodule

// File: tb/test_fm_dither.sv
module test_fm_dither;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W = 10;
    localparam int OUT_W = 8;
    localparam int LO_W = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic frame_start = 0;
    logic cfg_en = 0, cfg_deep = 0, cfg_prog = 0, cfg_bgr = 0;
    logic [7:0] cfg_smat = 0, cfg_tmat = 0;
    logic in_valid = 0;
    logic [11:0] in_x = 0, in_y = 0;
    logic [IN_W-1:0] in_r = 0, in_g = 0, in_b = 0;
    logic out_valid;
    logic [OUT_W-1:0] out_r, out_g, out_b;

    int checks = 0;
    int fails = 0;
    int fr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fm_dither i_fm_dither (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_en(cfg_en), .cfg_deep(cfg_deep), .cfg_prog(cfg_prog), .cfg_bgr(cfg_bgr),
        .cfg_smat(cfg_smat), .cfg_tmat(cfg_tmat),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model built from R3..R11
    function automatic int model(input int v, input int ch, input int x, input int y);
        int tr, g, mx, sidx, s, t, off, p;
        int bi[4] = '{0, 1, 3, 2};   // R7 built-in spatial phases
        if (cfg_deep) begin
            tr = v >> (IN_W-8); g = (v >> (IN_W-10)) & 3; mx = 255;
        end else begin
            tr = v >> (IN_W-6); g = (v >> (IN_W-8)) & 3; mx = 63;
        end
        if (!cfg_en) return tr;                          // R3
        sidx = (y & 1) * 2 + (x & 1);
        s = cfg_prog ? ((cfg_smat >> (2*sidx)) & 3) : bi[sidx];   // R8 / R7
        t = cfg_prog ? ((cfg_tmat >> (2*fr)) & 3) : fr;
        off = cfg_bgr ? (2 - ch) : ch;                   // R9
        p = (s + t + off) & 3;
        if (p < g && tr < mx) return tr + 1;             // R6, R11
        return tr;
    endfunction

    function automatic string label(input int v);
        int tr, g, mx;
        if (cfg_deep) begin tr = v >> (IN_W-8); g = (v >> (IN_W-10)) & 3; mx = 255; end
        else begin tr = v >> (IN_W-6); g = (v >> (IN_W-8)) & 3; mx = 63; end
        if (!cfg_en) return "R3";
        if (g == 0) return "R5";
        if (tr == mx) return "R11";
        if (cfg_prog) return "R8";
        if (cfg_bgr) return "R9";
        if (!cfg_deep) return "R4";
        return "R6";
    endfunction

    // Present one pixel at a negedge, check at the following negedge
    task automatic send(input int r, input int g, input int b, input int x, input int y);
        in_valid = 1; in_r = IN_W'(r); in_g = IN_W'(g); in_b = IN_W'(b);
        in_x = 12'(x); in_y = 12'(y);
        @(posedge clk); @(negedge clk);
        check("R1", int'(out_valid), 1);
        check(label(r), int'(out_r), model(r, 0, x, y));
        check(label(g), int'(out_g), model(g, 1, x, y));
        check(label(b), int'(out_b), model(b, 2, x, y));
    endtask

    // Frame pulse; R10 count tracked in the bench; R1 no valid output
    task automatic pulse_frame();
        in_valid = 0; frame_start = 1;
        @(posedge clk); @(negedge clk);
        frame_start = 0;
        fr = (fr + 1) % 4;
        check("R1", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        check("R2", int'(out_valid), 0);
        check("R2", int'(out_r), 0);
        check("R2", int'(out_b), 0);
        rst_n = 1;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        cfg_en = 1;
        for (int d = 0; d < 2; d++) begin
            for (int bg = 0; bg < 2; bg++) begin
                for (int pr = 0; pr < 2; pr++) begin
                    cfg_deep = d[0]; cfg_bgr = bg[0]; cfg_prog = pr[0];
                    cfg_smat = 8'h4E ^ 8'(d * 16 + bg * 3);
                    cfg_tmat = 8'hB1 ^ 8'(d * 4 + bg * 64);
                    for (int f = 0; f < 4; f++) begin
                        pulse_frame();   // R10: pattern follows frame count
                        for (int y = 0; y < 2; y++)
                            for (int x = 0; x < 2; x++) begin
                                for (int k = 0; k < 20; k++)
                                    send((k*53+7) % 1024, (k*97+300) % 1024, (k*151+11) % 1024,
                                         x + 6, y + 11);
                                send(1023, 1021, 1022, x, y);  // R11 saturation
                            end
                    end
                end
            end
        end

        // R1: outputs hold while idle
        in_valid = 0;
        @(posedge clk); @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_r), model(1023, 0, 1, 1));

        // R3: enable off gives plain truncation at both depths
        cfg_en = 0;
        for (int d = 0; d < 2; d++) begin
            cfg_deep = d[0];
            for (int k = 0; k < 16; k++)
                send((k*61+3) % 1024, (k*29+511) % 1024, 1023 - k*7, k, k + 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule